// File: doc/BRIEF.md
# Page-Mode EEPROM Write Sequencer

This block sits between a producer of bytes and a parallel, page-programmable EEPROM. A command gives a start address and a byte count. The block then pulls that many bytes over a valid/ready stream. It writes them to consecutive byte slots of a single page with chip-enable, write-enable and output-enable strobes, and the setup and pulse widths of those strobes are set by parameters. The strobes for consecutive bytes are paced so that each new write-enable fall lands inside the device's byte-load window.

After the last byte, the block stops driving writes and polls the last written location. Every poll is a read, and reads are separated by a fixed idle interval. While programming is in progress the device returns the complement of bit 7. The block reports completion once the read returns the written byte. It flags a timeout if a parameterised number of polls all return the wrong value. A stream that stalls long enough to endanger the load window ends the load early: the block starts polling and marks the operation truncated. A count of one gives a single-byte write.

Top module: `eep_page_writer`

## Requirements
- R1: During and after reset, mem_ce_n_o, mem_we_n_o and mem_oe_n_o are 1, and busy_o, data_ready_o, done_o, timeout_o and truncated_o are 0.
- R2: In idle, start_i with count_i in 1..2^PAGE_W launches an operation, and busy_o rises on the next cycle. A start with count_i of 0 or above 2^PAGE_W is ignored: busy_o stays 0 and no strobe moves.
- R3: Byte i of an operation is written to the address whose upper bits addr_i[ADDR_W-1:PAGE_W] are the ones given at start, and whose low PAGE_W bits are (addr_i[PAGE_W-1:0] + i) mod 2^PAGE_W. The upper bits never change within an operation.
- R4: For each byte write, mem_oe_n_o stays 1. mem_ce_n_o goes low SETUP_CYC cycles before mem_we_n_o falls. mem_we_n_o stays low for PULSE_CYC cycles. mem_ce_n_o stays low through one hold cycle after mem_we_n_o rises. mem_we_n_o is never low unless mem_ce_n_o is low.
- R5: Within an operation, two successive falls of mem_we_n_o are always fewer than LOAD_WIN_CYC cycles apart.
- R6: Once at least one byte has been written, if data_valid_i stays low for STALL_LIMIT = LOAD_WIN_CYC - SETUP_CYC - PULSE_CYC - 3 cycles while a byte is awaited, no further byte is taken. The block moves to polling, and truncated_o pulses together with the final done_o or timeout_o.
- R7: A poll read drives mem_ce_n_o and mem_oe_n_o low with mem_we_n_o high for READ_CYC cycles at the last written address. Successive reads are separated by POLL_GAP_CYC cycles with all strobes high.
- R8: When a poll read returns the full last written byte, which means its bit 7 is the true value and not the complement, done_o pulses for one cycle and the block returns to idle with busy_o low.
- R9: After POLL_LIMIT consecutive polls that do not match, timeout_o pulses for one cycle instead of done_o, and the block returns to idle.
- R10: A byte is taken only on a cycle with data_valid_i and data_ready_o both high. data_ready_o is high only while busy. Exactly count_i bytes are taken unless the operation is truncated.
- R11: A count of 1 performs a single byte write followed by polling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation (sampled in idle) |
| addr_i | input | ADDR_W | Page bits and first byte offset |
| count_i | input | PAGE_W+1 | Number of bytes, 1 to 2^PAGE_W |
| data_i | input | DATA_W | Stream byte |
| data_valid_i | input | 1 | Stream byte valid |
| data_ready_o | output | 1 | Block is ready to take a byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | One-cycle polling timeout pulse |
| truncated_o | output | 1 | Operation ended early on a stream stall |
| mem_addr_o | output | ADDR_W | EEPROM address bus |
| mem_wdata_o | output | DATA_W | EEPROM write data |
| mem_rdata_i | input | DATA_W | EEPROM read data |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |

## Verification
The bench builds the block with SETUP_CYC=2, PULSE_CYC=3, LOAD_WIN_CYC=40, POLL_GAP_CYC=4, READ_CYC=2 and POLL_LIMIT=20. With these values the stall limit is 32 cycles, so a 60-cycle stream pause causes a truncation within one test, while a 20-cycle pause shows the pacing holding just below the window. A device model that stays busy forever reaches the timeout after 20 polls, about 120 cycles. A 64-byte load, a load that wraps from offset 62 to offset 1, and a single byte all fit easily within the run.

// File: rtl/eep_pw_pkg.sv
package eep_pw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_GAP,
    ST_READ
  } pw_state_e;
endpackage

// File: rtl/eep_pw_timer.sv
module eep_pw_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/eep_pw_counter.sv
module eep_pw_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clr_i)   cnt_o <= '0;
    else if (inc_i)   cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/eep_pw_poll_judge.sv
module eep_pw_poll_judge #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] target_i,
  output logic              match_o
);
  // the top bit carries the in-progress complement; require the whole byte
  assign match_o = (rdata_i[DATA_W-1] == target_i[DATA_W-1]) &&
                   (rdata_i[DATA_W-2:0] == target_i[DATA_W-2:0]);
endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer #(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int PAGE_W       = 6,
  parameter int SETUP_CYC    = 2,
  parameter int PULSE_CYC    = 5,
  parameter int LOAD_WIN_CYC = 7500,
  parameter int POLL_GAP_CYC = 50,
  parameter int READ_CYC     = 8,
  parameter int POLL_LIMIT   = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PAGE_W:0]   count_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              data_valid_i,
  output logic              data_ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              truncated_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_ce_n_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o
);
  import eep_pw_pkg::*;

  localparam int CNT_W       = PAGE_W + 1;
  localparam int PG_W        = ADDR_W - PAGE_W;
  localparam int PAGE_SIZE   = 1 << PAGE_W;
  localparam int STALL_LIMIT = LOAD_WIN_CYC - SETUP_CYC - PULSE_CYC - 3;
  localparam int SW          = $clog2(LOAD_WIN_CYC + 1);
  localparam int PW          = $clog2(POLL_LIMIT + 1);
  localparam int M1          = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int M2          = (POLL_GAP_CYC > READ_CYC) ? POLL_GAP_CYC : READ_CYC;
  localparam int TMR_MAX     = (M1 > M2) ? M1 : M2;
  localparam int TMR_W       = $clog2(TMR_MAX + 1);

  pw_state_e state_q, state_d;

  logic [PG_W-1:0]   page_q;
  logic [PAGE_W-1:0] base_q, last_off_q, wr_off;
  logic [CNT_W-1:0]  total_q, idx_q;
  logic [DATA_W-1:0] wdata_q, last_data_q;
  logic              trunc_q;

  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              stall_clr, stall_inc, stall_hit;
  logic [SW-1:0]     stall_cnt;
  logic              poll_inc;
  logic [PW-1:0]     poll_cnt;
  logic              read_match;

  logic cmd_ok, launch, accept, byte_done, done_set, to_set, trunc_set;

  logic              ce_n_q, we_n_q, oe_n_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q, to_q, tr_q;

  assign cmd_ok = start_i && (count_i != '0) && (count_i <= CNT_W'(PAGE_SIZE));
  assign wr_off = base_q + idx_q[PAGE_W-1:0];

  eep_pw_timer #(.W(TMR_W)) i_phase_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  assign stall_clr = (state_q != ST_FETCH) || accept;
  assign stall_inc = (state_q == ST_FETCH) && !data_valid_i && (idx_q != '0);
  assign stall_hit = (stall_cnt == SW'(STALL_LIMIT));

  eep_pw_counter #(.W(SW)) i_stall_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (stall_clr),
    .inc_i  (stall_inc),
    .cnt_o  (stall_cnt)
  );

  eep_pw_counter #(.W(PW)) i_poll_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (launch),
    .inc_i  (poll_inc),
    .cnt_o  (poll_cnt)
  );

  eep_pw_poll_judge #(.DATA_W(DATA_W)) i_judge (
    .rdata_i  (mem_rdata_i),
    .target_i (last_data_q),
    .match_o  (read_match)
  );

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    launch    = 1'b0;
    accept    = 1'b0;
    byte_done = 1'b0;
    done_set  = 1'b0;
    to_set    = 1'b0;
    trunc_set = 1'b0;
    poll_inc  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_ok) begin
          launch  = 1'b1;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (data_valid_i) begin
          accept   = 1'b1;
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(SETUP_CYC - 1);
        end else if (stall_hit) begin
          // window at risk: stop loading, go verify what was written
          trunc_set = 1'b1;
          state_d   = ST_GAP;
          tmr_load  = 1'b1;
          tmr_val   = TMR_W'(POLL_GAP_CYC - 1);
        end
      end
      ST_SETUP: begin
        if (tmr_zero) begin
          state_d  = ST_PULSE;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(PULSE_CYC - 1);
        end
      end
      ST_PULSE: begin
        if (tmr_zero) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        byte_done = 1'b1;
        if ((idx_q + CNT_W'(1)) == total_q) begin
          state_d  = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(POLL_GAP_CYC - 1);
        end else begin
          state_d = ST_FETCH;
        end
      end
      ST_GAP: begin
        if (tmr_zero) begin
          state_d  = ST_READ;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(READ_CYC - 1);
        end
      end
      ST_READ: begin
        if (tmr_zero) begin
          if (read_match) begin
            done_set = 1'b1;
            state_d  = ST_IDLE;
          end else if (poll_cnt == PW'(POLL_LIMIT - 1)) begin
            to_set  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            poll_inc = 1'b1;
            state_d  = ST_GAP;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(POLL_GAP_CYC - 1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      page_q      <= '0;
      base_q      <= '0;
      total_q     <= '0;
      idx_q       <= '0;
      wdata_q     <= '0;
      last_off_q  <= '0;
      last_data_q <= '0;
      trunc_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (launch) begin
        page_q  <= addr_i[ADDR_W-1:PAGE_W];
        base_q  <= addr_i[PAGE_W-1:0];
        total_q <= count_i;
        idx_q   <= '0;
        trunc_q <= 1'b0;
      end
      if (accept) wdata_q <= data_i;
      if (byte_done) begin
        idx_q       <= idx_q + CNT_W'(1);
        last_off_q  <= wr_off;
        last_data_q <= wdata_q;
      end
      if (trunc_set) trunc_q <= 1'b1;
    end
  end

  // strobes registered from the next state so they align with the state, glitch free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_q <= 1'b1;
      we_n_q <= 1'b1;
      oe_n_q <= 1'b1;
      addr_q <= '0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
      tr_q   <= 1'b0;
    end else begin
      ce_n_q <= !(state_d inside {ST_SETUP, ST_PULSE, ST_HOLD, ST_READ});
      we_n_q <= (state_d != ST_PULSE);
      oe_n_q <= (state_d != ST_READ);
      addr_q <= (state_d == ST_READ) ? {page_q, last_off_q} : {page_q, wr_off};
      done_q <= done_set;
      to_q   <= to_set;
      tr_q   <= (done_set || to_set) && trunc_q;
    end
  end

  assign mem_ce_n_o   = ce_n_q;
  assign mem_we_n_o   = we_n_q;
  assign mem_oe_n_o   = oe_n_q;
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = wdata_q;
  assign done_o       = done_q;
  assign timeout_o    = to_q;
  assign truncated_o  = tr_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign data_ready_o = (state_q == ST_FETCH);
endmodule

// File: rtl/eep_pw_checker.sv
module eep_pw_checker #(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int PAGE_W       = 6,
  parameter int LOAD_WIN_CYC = 7500
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [PAGE_W:0]   count_i,
  input logic              data_valid_i,
  input logic              data_ready_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              timeout_o,
  input logic              truncated_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_n_o,
  input logic              mem_we_n_o,
  input logic              mem_oe_n_o
);
  localparam int GW = $clog2(LOAD_WIN_CYC + 2);
  localparam int PAGE_SIZE = 1 << PAGE_W;

  logic [ADDR_W-PAGE_W-1:0] page_cap;
  logic [GW-1:0]            gap_cnt;
  logic                     armed, we_prev, launch_seen;

  assign launch_seen = start_i && !busy_o && (count_i != '0) &&
                       (int'(count_i) <= PAGE_SIZE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_cap <= '0;
      gap_cnt  <= '0;
      armed    <= 1'b0;
      we_prev  <= 1'b1;
    end else begin
      we_prev <= mem_we_n_o;
      if (launch_seen) begin
        page_cap <= addr_i[ADDR_W-1:PAGE_W];
        armed    <= 1'b0;
      end else if (we_prev && !mem_we_n_o) begin
        armed <= 1'b1;
      end
      if (we_prev && !mem_we_n_o)        gap_cnt <= GW'(1);
      else if (gap_cnt != {GW{1'b1}})    gap_cnt <= gap_cnt + GW'(1);
    end
  end

  p_idle_strobes_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (mem_we_n_o && mem_oe_n_o));

  p_bad_count_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (count_i == '0)) |=> !busy_o);

  p_page_fixed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_n_o) |-> (mem_addr_o[ADDR_W-1:PAGE_W] == page_cap));

  p_we_under_ce_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (!mem_ce_n_o && mem_oe_n_o));

  p_load_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(mem_we_n_o) && armed) |-> (int'(gap_cnt) < LOAD_WIN_CYC));

  p_trunc_with_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    truncated_o |-> (done_o || timeout_o));

  p_read_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (!mem_ce_n_o && mem_we_n_o));

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_end_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));

  p_ready_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o |-> busy_o);

  p_take_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_ready_o && data_valid_i) |=> !data_ready_o);
endmodule

bind eep_page_writer eep_pw_checker #(
  .ADDR_W       (ADDR_W),
  .DATA_W       (DATA_W),
  .PAGE_W       (PAGE_W),
  .LOAD_WIN_CYC (LOAD_WIN_CYC)
) i_eep_pw_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .addr_i       (addr_i),
  .count_i      (count_i),
  .data_valid_i (data_valid_i),
  .data_ready_o (data_ready_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .timeout_o    (timeout_o),
  .truncated_o  (truncated_o),
  .mem_addr_o   (mem_addr_o),
  .mem_ce_n_o   (mem_ce_n_o),
  .mem_we_n_o   (mem_we_n_o),
  .mem_oe_n_o   (mem_oe_n_o)
);

// File: tb/test_eep_page_writer.sv
module test_eep_page_writer;
  localparam int ADDR_W = 15, DATA_W = 8, PAGE_W = 6;
  localparam int SETUP = 2, PULSE = 3, WIN = 40, GAP = 4, RD = 2, PLIM = 20;
  localparam int PROG = 40;

  logic clk = 0, rst_ni = 0;
  logic start_i = 0, data_valid_i = 0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [PAGE_W:0] count_i = '0;
  logic [7:0] data_i = '0;
  logic data_ready_o, busy_o, done_o, timeout_o, truncated_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [7:0] mem_wdata_o, mem_rdata_i;
  logic mem_ce_n_o, mem_we_n_o, mem_oe_n_o;

  always #10 clk = ~clk;

  eep_page_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W),
    .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .LOAD_WIN_CYC(WIN),
    .POLL_GAP_CYC(GAP), .READ_CYC(RD), .POLL_LIMIT(PLIM)) i_eep_page_writer (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .count_i(count_i), .data_i(data_i), .data_valid_i(data_valid_i),
    .data_ready_o(data_ready_o), .busy_o(busy_o), .done_o(done_o),
    .timeout_o(timeout_o), .truncated_o(truncated_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .mem_ce_n_o(mem_ce_n_o), .mem_we_n_o(mem_we_n_o), .mem_oe_n_o(mem_oe_n_o));

  int checks = 0, errors = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---- device model and per-clock protocol reference ----
  logic [7:0] mem [64];
  logic [7:0] last_wr = '0;
  int prog_cnt = 0;
  bit stuck = 0;
  logic [ADDR_W-1:0] exp_addr_q[$];
  logic [7:0] exp_data_q[$];
  logic [ADDR_W-1:0] last_addr = '0;
  int ce_run = 0, we_run = 0, oe_run = 0, idle_run = 0, fall_gap = 0;
  bit have_fall = 0;
  int reads_in_op = 0;
  logic p_we = 1, p_oe = 1;

  initial for (int i = 0; i < 64; i++) mem[i] = '0;

  always_comb begin
    if (prog_cnt != 0) mem_rdata_i = {~last_wr[7], last_wr[6:0]};
    else               mem_rdata_i = mem[mem_addr_o[5:0]];
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      if (!mem_we_n_o && (mem_ce_n_o || !mem_oe_n_o))
        chk(0, "R4", "write strobe without ce or with oe", 1, 0);
      if (!mem_oe_n_o && (mem_ce_n_o || !mem_we_n_o))
        chk(0, "R7", "read strobe shape", 1, 0);
      if (done_o) chk(prog_cnt == 0, "R8", "done while device busy", prog_cnt, 0);
      if (p_we && !mem_we_n_o) begin
        chk(ce_run == SETUP, "R4", "ce setup before we fall", ce_run, SETUP);
        if (have_fall) chk(fall_gap < WIN, "R5", "gap between we falls", fall_gap, WIN - 1);
        have_fall = 1;
        fall_gap = 0;
      end
      if (!p_we && mem_we_n_o) begin
        chk(we_run == PULSE, "R4", "we pulse width", we_run, PULSE);
        chk(!mem_ce_n_o, "R4", "ce held after we rise", mem_ce_n_o, 0);
        if (exp_addr_q.size() == 0) chk(0, "R10", "unexpected write", 1, 0);
        else begin
          chk(mem_addr_o == exp_addr_q[0], "R3", "write address", mem_addr_o, exp_addr_q[0]);
          chk(mem_wdata_o == exp_data_q[0], "R10", "write data", mem_wdata_o, exp_data_q[0]);
          void'(exp_addr_q.pop_front());
          void'(exp_data_q.pop_front());
        end
        mem[mem_addr_o[5:0]] = mem_wdata_o;
        last_wr = mem_wdata_o;
        last_addr = mem_addr_o;
        prog_cnt = PROG;
      end
      if (p_oe && !mem_oe_n_o) begin
        chk(mem_addr_o == last_addr, "R7", "poll address", mem_addr_o, last_addr);
        if (reads_in_op > 0) chk(idle_run == GAP, "R7", "gap between polls", idle_run, GAP);
        reads_in_op++;
      end
      if (!p_oe && mem_oe_n_o) chk(oe_run == RD, "R7", "read width", oe_run, RD);
      ce_run   = mem_ce_n_o ? 0 : ce_run + 1;
      idle_run = mem_ce_n_o ? idle_run + 1 : 0;
      we_run   = mem_we_n_o ? 0 : we_run + 1;
      oe_run   = mem_oe_n_o ? 0 : oe_run + 1;
      fall_gap++;
      if (prog_cnt > 0 && !stuck) prog_cnt--;
      p_we = mem_we_n_o;
      p_oe = mem_oe_n_o;
    end
  end

  // ---- watchdog ----
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---- stimulus ----
  logic [7:0] src[$];
  int n_acc = 0;

  task automatic feed(int n, int stall_at, int stall_len);
    for (int i = 0; i < n; i++) begin
      if (i == stall_at) repeat (stall_len) @(negedge clk);
      else repeat (i % 3) @(negedge clk);
      data_i = src[i];
      data_valid_i = 1;
      while (!data_ready_o) @(negedge clk);
      @(negedge clk);
      n_acc++;
      data_valid_i = 0;
    end
  endtask

  task automatic run_op(string tag, int off, int page, int cnt, int stall_at, int stall_len,
                        bit stk, bit exp_tr, bit exp_to);
    int n_exp, c;
    bit got_done, got_to, got_tr;
    n_exp = exp_tr ? stall_at : cnt;
    stuck = stk;
    src.delete();
    for (int i = 0; i < cnt; i++) src.push_back(8'(i * 37 + off * 11 + cnt * 3 + 5));
    for (int i = 0; i < n_exp; i++) begin
      exp_addr_q.push_back(ADDR_W'((page << PAGE_W) | ((off + i) % 64)));
      exp_data_q.push_back(src[i]);
    end
    reads_in_op = 0;
    have_fall = 0;
    n_acc = 0;
    @(negedge clk);
    addr_i = ADDR_W'((page << PAGE_W) | off);
    count_i = 7'(cnt);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(busy_o == 1, "R2", {tag, " busy after start"}, busy_o, 1);
    fork
      feed(cnt, stall_at, stall_len);
    join_none
    c = 0;
    while (!(done_o || timeout_o) && c < 6000) begin
      @(negedge clk);
      c++;
    end
    got_done = done_o; got_to = timeout_o; got_tr = truncated_o;
    disable fork;
    data_valid_i = 0;
    chk(c < 6000, "R8", {tag, " operation ended"}, c, 0);
    chk(got_done == !exp_to, exp_to ? "R9" : "R8", {tag, " done flag"}, got_done, !exp_to);
    chk(got_to == exp_to, "R9", {tag, " timeout flag"}, got_to, exp_to);
    chk(got_tr == exp_tr, "R6", {tag, " truncated flag"}, got_tr, exp_tr);
    chk(n_acc == n_exp, "R10", {tag, " bytes taken"}, n_acc, n_exp);
    chk(exp_addr_q.size() == 0, "R3", {tag, " writes outstanding"}, exp_addr_q.size(), 0);
    for (int i = 0; i < n_exp; i++)
      chk(mem[(off + i) % 64] == src[i], "R3", {tag, " stored byte"}, mem[(off + i) % 64], src[i]);
    if (exp_to) chk(reads_in_op == PLIM, "R9", {tag, " polls before timeout"}, reads_in_op, PLIM);
    @(negedge clk);
    chk(!done_o && !timeout_o && !busy_o, "R8", {tag, " idle after end"}, busy_o, 0);
    exp_addr_q.delete();
    exp_data_q.delete();
    stuck = 0;
    repeat (PROG + 5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n_o && mem_we_n_o && mem_oe_n_o, "R1", "strobes in reset", 0, 1);
    chk(!busy_o && !data_ready_o && !done_o && !timeout_o && !truncated_o, "R1",
        "status in reset", busy_o, 0);
    rst_ni = 1;
    @(negedge clk);
    chk(mem_ce_n_o && mem_we_n_o && mem_oe_n_o && !busy_o, "R1", "after reset", busy_o, 0);

    // ignored starts
    addr_i = 15'h0123; count_i = 7'd0; start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(!busy_o && mem_ce_n_o, "R2", "count 0 ignored", busy_o, 0);
    count_i = 7'd65; start_i = 1;
    @(negedge clk);
    start_i = 0;
    repeat (3) @(negedge clk);
    chk(!busy_o && mem_ce_n_o, "R2", "count 65 ignored", busy_o, 0);

    run_op("R11 single", 5, 3, 1, -1, 0, 0, 0, 0);
    run_op("page8", 10, 7, 8, -1, 0, 0, 0, 0);
    run_op("R3 wrap", 62, 100, 4, -1, 0, 0, 0, 0);
    run_op("full64", 0, 511, 64, -1, 0, 0, 0, 0);
    run_op("R5 short stall", 20, 2, 6, 3, 20, 0, 0, 0);
    run_op("R6 long stall", 30, 9, 8, 3, 60, 0, 1, 0);
    run_op("R9 stuck", 40, 4, 2, -1, 0, 1, 0, 1);
    run_op("after timeout", 41, 4, 3, -1, 0, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule